// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block decides which program word the core fetches next. It holds a program counter up to 13 bits wide and a 5-bit high-address latch. It also holds a circular return stack of 13-bit entries. Each cycle the decode logic raises at most one of several strobes: step forward, skip one word, load the low byte from the data bus, jump, call, return, return with a literal, or enter the interrupt handler. When several strobes arrive together, a fixed priority picks one of them. Two cases take only part of the address from their own source. Jumps and calls supply 11 bits, and the top two bits come from the latch. A write to the low byte supplies 8 bits, and the top five come from the latch.

The stack keeps the most recent return addresses. When it is full, the next push overwrites the oldest entry without any notice. A return on an empty stack reads whatever slot the pointer wraps to. The parameter `IMPL_W` sets how many counter bits are built. The bits above it always read zero, so smaller parts see their code space mirrored.

Top module: `seq_pc_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0 and all stack slots hold 0.
- R2: With only the advance strobe, the fetch address becomes (PC+1) modulo 2^IMPL_W on the next cycle. The low-byte output always equals fetch address bits 7:0.
- R3: With only the skip strobe, the fetch address becomes (PC+2) modulo 2^IMPL_W.
- R4: A low-byte write loads PC[7:0] from the data bus and PC[12:8] from latch bits 4:0.
- R5: A jump loads PC[10:0] from the target field and PC[12:11] from latch bits 4:3.
- R6: A call loads the PC the same way as a jump and pushes PC+1.
- R7: Interrupt entry pushes PC+1 and loads the PC with 0x004.
- R8: A plain return and a return-with-literal both pop the most recent pushed address into the PC, in last-in, first-out order.
- R9: While the return-with-literal strobe is high, the literal output equals target bits 7:0 and the literal-valid output is 1. Otherwise literal-valid is 0.
- R10: The stack holds 8 entries. A ninth push without a pop overwrites the oldest entry, and later pops return the newest 8 pushes and then wrap.
- R11: A pop from an empty stack raises no error. It returns the entry in the slot the 3-bit pointer wraps to.
- R12: PC bits at position IMPL_W and above read as 0 in every cycle.
- R13: A latch write stores data bits 4:0 for later cycles. A PC load in the same cycle uses the previous latch value.
- R14: Priority from highest to lowest is interrupt, call, jump, return, return-with-literal, low-byte write, skip, advance. With no strobe the PC holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Step to next word |
| skip_i | input | 1 | Step over one word |
| pcl_wr_i | input | 1 | Computed jump through low-byte write |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Return (plain or from interrupt) |
| retlw_i | input | 1 | Return with literal |
| irq_i | input | 1 | Interrupt entry |
| latch_wr_i | input | 1 | Load high-address latch from data bus |
| target_i | input | 11 | Instruction target or literal field |
| data_i | input | 8 | Data bus |
| fetch_addr_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Readable low byte of the counter |
| lit_o | output | 8 | Literal presented on return-with-literal |
| lit_vld_o | output | 1 | Literal is valid this cycle |

## Verification
The hardest state to reach is a stack that has wrapped: nine or more nested calls, followed by enough returns to unwind past the overwritten slot and on into underflow. The bench does this on purpose with a run of nine calls to distinct targets and then eleven returns. A second instance built with 11 implemented bits runs on the same stimulus, so every jump and low-byte write also exercises the mirroring. A long random phase then mixes overlapping strobes to exercise the priority order.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        ACT_HOLD,
        ACT_ADV,
        ACT_SKIP,
        ACT_PCLW,
        ACT_RETLW,
        ACT_RET,
        ACT_JUMP,
        ACT_CALL,
        ACT_IRQ
    } seq_act_e;

    // fixed priority: interrupt first, plain advance last
    function automatic seq_act_e seq_pick(
        input logic irq, input logic call, input logic jump,
        input logic ret, input logic retlw, input logic pclw,
        input logic skip, input logic adv);
        if (irq)        return ACT_IRQ;
        else if (call)  return ACT_CALL;
        else if (jump)  return ACT_JUMP;
        else if (ret)   return ACT_RET;
        else if (retlw) return ACT_RETLW;
        else if (pclw)  return ACT_PCLW;
        else if (skip)  return ACT_SKIP;
        else if (adv)   return ACT_ADV;
        else            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] ptr_d, ptr_q;
    logic [PTR_W-1:0] top_idx;
    logic [DEPTH-1:0] slot_we;
    logic [W-1:0]     slot_q [DEPTH];

    // per-slot write enables; pointer wraps, so the oldest slot is reused
    for (genvar e = 0; e < DEPTH; e++) begin : g_we
        assign slot_we[e] = push_i && (ptr_q == PTR_W'(e));
    end

    assign top_idx   = ptr_q - PTR_W'(1);
    assign rd_data_o = slot_q[top_idx];

    always_comb begin
        ptr_d = ptr_q;
        if (push_i)     ptr_d = ptr_q + PTR_W'(1);
        else if (pop_i) ptr_d = top_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            for (int i = 0; i < DEPTH; i++)
                if (slot_we[i]) slot_q[i] <= wr_data_i;
        end
    end

endmodule

// File: rtl/seq_next_pc.sv
module seq_next_pc
    import seq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int TGT_W   = 11,
    parameter int LATCH_W = 5,
    parameter int BYTE_W  = 8,
    parameter int IMPL_W  = 13,
    parameter int VECTOR  = 4
) (
    input  seq_act_e            act_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [LATCH_W-1:0]  latch_i,
    input  logic [TGT_W-1:0]    target_i,
    input  logic [BYTE_W-1:0]   data_i,
    input  logic [ADDR_W-1:0]   pop_data_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic                push_o,
    output logic                pop_o,
    output logic [ADDR_W-1:0]   push_data_o
);
    localparam int PAGE_W = ADDR_W - TGT_W;
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - IMPL_W);

    logic [ADDR_W-1:0] inc1, inc2, far_tgt, computed, raw;

    assign inc1     = pc_i + ADDR_W'(1);
    assign inc2     = pc_i + ADDR_W'(2);
    assign far_tgt  = {latch_i[LATCH_W-1 -: PAGE_W], target_i};
    assign computed = {latch_i, data_i};

    always_comb begin
        raw    = pc_i;
        push_o = 1'b0;
        pop_o  = 1'b0;
        unique case (act_i)
            ACT_IRQ:   begin raw = ADDR_W'(VECTOR); push_o = 1'b1; end
            ACT_CALL:  begin raw = far_tgt;         push_o = 1'b1; end
            ACT_JUMP:        raw = far_tgt;
            ACT_RET,
            ACT_RETLW: begin raw = pop_data_i;      pop_o  = 1'b1; end
            ACT_PCLW:        raw = computed;
            ACT_SKIP:        raw = inc2;
            ACT_ADV:         raw = inc1;
            default:         raw = pc_i;
        endcase
    end

    assign pc_o        = raw & MASK;
    assign push_data_o = inc1 & MASK;

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int TGT_W   = 11,
    parameter int LATCH_W = 5,
    parameter int BYTE_W  = 8,
    parameter int IMPL_W  = 13,
    parameter int DEPTH   = 8,
    parameter int VECTOR  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv_i,
    input  logic                          skip_i,
    input  logic                          pcl_wr_i,
    input  logic                          jump_i,
    input  logic                          call_i,
    input  logic                          ret_i,
    input  logic                          retlw_i,
    input  logic                          irq_i,
    input  logic                          latch_wr_i,
    input  logic [TGT_W-1:0]              target_i,
    input  logic [BYTE_W-1:0]             data_i,
    output logic [LATCH_W+BYTE_W-1:0]     fetch_addr_o,
    output logic [BYTE_W-1:0]             pcl_o,
    output logic [BYTE_W-1:0]             lit_o,
    output logic                          lit_vld_o
);
    localparam int ADDR_W = LATCH_W + BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic [LATCH_W-1:0] latch;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    seq_act_e          act;
    logic [ADDR_W-1:0] pc_nxt, push_data, pop_data;
    logic              push, pop;

    assign act = seq_pick(irq_i, call_i, jump_i, ret_i, retlw_i,
                          pcl_wr_i, skip_i, adv_i);

    seq_next_pc #(
        .ADDR_W(ADDR_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W),
        .BYTE_W(BYTE_W), .IMPL_W(IMPL_W), .VECTOR(VECTOR)
    ) u_next (
        .act_i       (act),
        .pc_i        (st_q.pc),
        .latch_i     (st_q.latch),
        .target_i    (target_i),
        .data_i      (data_i),
        .pop_data_i  (pop_data),
        .pc_o        (pc_nxt),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    seq_ret_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_i     (pop),
        .wr_data_i (push_data),
        .rd_data_o (pop_data)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nxt;
        if (latch_wr_i) st_d.latch = data_i[LATCH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign pcl_o        = st_q.pc[BYTE_W-1:0];
    assign lit_o        = target_i[BYTE_W-1:0];
    assign lit_vld_o    = retlw_i;

endmodule

// File: rtl/seq_pc_chk.sv
module seq_pc_chk #(
    parameter int ADDR_W = 13,
    parameter int TGT_W  = 11,
    parameter int BYTE_W = 8,
    parameter int IMPL_W = 13,
    parameter int VECTOR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              skip_i,
    input logic              pcl_wr_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              retlw_i,
    input logic              irq_i,
    input logic [TGT_W-1:0]  target_i,
    input logic [BYTE_W-1:0] data_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [BYTE_W-1:0] lit_o,
    input logic              lit_vld_o
);
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - IMPL_W);

    logic adv_only, pcl_only, jump_only, call_only, ret_only;
    assign adv_only  = adv_i && !skip_i && !pcl_wr_i && !jump_i && !call_i
                       && !ret_i && !retlw_i && !irq_i;
    assign pcl_only  = pcl_wr_i && !jump_i && !call_i && !ret_i && !retlw_i && !irq_i;
    assign jump_only = jump_i && !call_i && !irq_i;
    assign call_only = call_i && !irq_i;
    assign ret_only  = ret_i && !jump_i && !call_i && !irq_i;

    // R2
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_only |=> fetch_addr_o == (($past(fetch_addr_o) + ADDR_W'(1)) & MASK));

    // R4
    pcl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcl_only |=> fetch_addr_o[BYTE_W-1:0] == ($past(data_i) & MASK[BYTE_W-1:0]));

    // R5
    jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_only |=> fetch_addr_o[TGT_W-1:0] == ($past(target_i) & MASK[TGT_W-1:0]));

    // R7
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> fetch_addr_o == (ADDR_W'(VECTOR) & MASK));

    // R8
    call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_only && $past(call_only) && $past(rst_n))
        |=> fetch_addr_o == (($past(fetch_addr_o, 2) + ADDR_W'(1)) & MASK));

    // R9
    lit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lit_vld_o == retlw_i);

    // R12
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_addr_o & ~MASK) == '0);

endmodule

bind seq_pc_unit seq_pc_chk #(
    .ADDR_W(ADDR_W), .TGT_W(TGT_W), .BYTE_W(BYTE_W),
    .IMPL_W(IMPL_W), .VECTOR(VECTOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .skip_i(skip_i),
    .pcl_wr_i(pcl_wr_i), .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
    .retlw_i(retlw_i), .irq_i(irq_i), .target_i(target_i), .data_i(data_i),
    .fetch_addr_o(fetch_addr_o), .lit_o(lit_o), .lit_vld_o(lit_vld_o)
);

// File: tb/tb_seq_pc_unit.sv
module tb_seq_pc_unit;

    localparam int C_ADV = 1, C_SKIP = 2, C_PCL = 4, C_JMP = 8, C_CALL = 16,
                   C_RET = 32, C_RLW = 64, C_IRQ = 128, C_LW = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_i = 0, skip_i = 0, pcl_wr_i = 0, jump_i = 0, call_i = 0;
    logic ret_i = 0, retlw_i = 0, irq_i = 0, latch_wr_i = 0;
    logic [10:0] target_i = '0;
    logic [7:0]  data_i = '0;
    logic [12:0] fa [2];
    logic [7:0]  pl [2];
    logic [7:0]  lit [2];
    logic        lv [2];

    int checks = 0;
    int errors = 0;

    int pc_m [2];
    int stk [2][$];
    int lat;
    int msk [2] = '{32'h1FFF, 32'h07FF};

    always #5ns clk = ~clk;

    seq_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .skip_i(skip_i),
        .pcl_wr_i(pcl_wr_i), .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
        .retlw_i(retlw_i), .irq_i(irq_i), .latch_wr_i(latch_wr_i),
        .target_i(target_i), .data_i(data_i), .fetch_addr_o(fa[0]),
        .pcl_o(pl[0]), .lit_o(lit[0]), .lit_vld_o(lv[0]));

    seq_pc_unit #(.IMPL_W(11)) dut_m (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .skip_i(skip_i),
        .pcl_wr_i(pcl_wr_i), .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
        .retlw_i(retlw_i), .irq_i(irq_i), .latch_wr_i(latch_wr_i),
        .target_i(target_i), .data_i(data_i), .fetch_addr_o(fa[1]),
        .pcl_o(pl[1]), .lit_o(lit[1]), .lit_vld_o(lv[1]));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_push(input int k, input int v);
        void'(stk[k].pop_front());
        stk[k].push_back(v);
    endtask

    task automatic cyc(input int ctl, input int tgt, input int dat, input string tag);
        int n1, np, v;
        adv_i = (ctl & C_ADV) != 0;   skip_i  = (ctl & C_SKIP) != 0;
        pcl_wr_i = (ctl & C_PCL) != 0; jump_i = (ctl & C_JMP) != 0;
        call_i = (ctl & C_CALL) != 0; ret_i   = (ctl & C_RET) != 0;
        retlw_i = (ctl & C_RLW) != 0; irq_i   = (ctl & C_IRQ) != 0;
        latch_wr_i = (ctl & C_LW) != 0;
        target_i = tgt[10:0]; data_i = dat[7:0];
        #1;
        for (int k = 0; k < 2; k++) begin
            check("R9 lit_vld", int'(lv[k]), int'(retlw_i));
            if (retlw_i) check("R9 literal", int'(lit[k]), tgt & 'hFF);
        end
        for (int k = 0; k < 2; k++) begin
            n1 = (pc_m[k] + 1) & msk[k];
            if (irq_i) begin model_push(k, n1); np = 4 & msk[k]; end
            else if (call_i || jump_i) begin
                if (call_i) model_push(k, n1);
                np = ((((lat >> 3) & 3) << 11) | (tgt & 'h7FF)) & msk[k];
            end else if (ret_i || retlw_i) begin
                v = stk[k].pop_back();
                stk[k].push_front(v);
                np = v;
            end else if (pcl_wr_i) np = (((lat & 31) << 8) | (dat & 'hFF)) & msk[k];
            else if (skip_i) np = (pc_m[k] + 2) & msk[k];
            else if (adv_i) np = n1;
            else np = pc_m[k];
            pc_m[k] = np;
        end
        if (latch_wr_i) lat = dat & 31;
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            check(tag, int'(fa[k]), pc_m[k]);
            check("R2 pcl_o", int'(pl[k]), pc_m[k] & 'hFF);
        end
    endtask

    initial begin
        #2_000_000ns;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        lat = 0;
        for (int k = 0; k < 2; k++) begin
            pc_m[k] = 0;
            for (int i = 0; i < 8; i++) stk[k].push_back(0);
        end
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) check("R1 reset pc", int'(fa[k]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < 2; k++) check("R1 first cycle pc", int'(fa[k]), 0);

        // R11: pop on fresh stack returns a zero slot
        cyc(C_RET, 0, 0, "R11 underflow after reset");
        cyc(C_ADV, 0, 0, "R2 advance");
        cyc(C_ADV, 0, 0, "R2 advance");
        cyc(C_SKIP, 0, 0, "R3 skip");
        cyc(0, 0, 0, "R14 hold");
        // R13: latch write plus jump uses old latch (0)
        cyc(C_LW | C_JMP, 11'h523, 8'h1A, "R13 old latch");
        cyc(C_JMP, 11'h123, 0, "R5 jump with latch 1A");
        cyc(C_PCL, 0, 8'h45, "R4 computed jump");
        // R6 / R8 nesting
        cyc(C_CALL, 11'h300, 0, "R6 call 1");
        cyc(C_ADV, 0, 0, "R2 advance in sub");
        cyc(C_CALL, 11'h400, 0, "R6 call 2");
        cyc(C_RET, 0, 0, "R8 return inner");
        cyc(C_RLW, 11'h0A5, 0, "R8 retlw outer");
        // R7 priority over everything
        cyc(C_IRQ | C_CALL | C_JMP | C_RET | C_ADV, 11'h222, 0, "R7 interrupt");
        cyc(C_CALL | C_JMP | C_PCL | C_SKIP, 11'h0F0, 8'h11, "R14 call wins");
        cyc(C_RET | C_RLW | C_PCL, 11'h033, 8'h22, "R14 ret wins");
        cyc(C_RET, 0, 0, "R8 return from interrupt");
        // R10 overflow: nine calls, then eleven returns into underflow
        for (int i = 0; i < 9; i++) cyc(C_CALL, 11'h100 + i * 16, 0, "R10 deep call");
        for (int i = 0; i < 11; i++) cyc(C_RET, 0, 0, "R10 R11 unwind");
        // R2 wrap at top of implemented space
        cyc(C_LW, 0, 8'h1F, "R13 latch load");
        cyc(C_PCL, 0, 8'hFF, "R4 top address");
        cyc(C_ADV, 0, 0, "R2 R12 wrap");
        cyc(C_SKIP | C_ADV, 0, 0, "R14 skip over advance");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int r, c;
            r = int'($urandom_range(0, 99));
            if (r < 50) c = C_ADV;
            else c = int'($urandom_range(0, 511));
            cyc(c, int'($urandom_range(0, 2047)), int'($urandom_range(0, 255)),
                "R14 random mix");
        end
        cyc(0, 0, 0, "R14 idle");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule